// File: doc/BRIEF.md
# BCD Clock-Calendar Core with Frozen Host View

This block counts time of day and calendar date in packed BCD: hundredths of a second, seconds, minutes, hours, weekday, date, month and two-digit year. It advances once per pulse on a 100 Hz tick input, which is already divided down from the oscillator outside the block. Two copies of the time are held. The running copy counts. The host-visible copy is what the register port reads and writes. A transfer-enable control lets the host freeze the visible copy so that a multi-byte read or write sees consistent values. Counting continues underneath, so no time is lost while the view is frozen.

The hours register carries its own 12/24-hour selection and AM/PM flag. The month register carries two active-low controls: one halts the clock and one enables a 1024 Hz square-wave output. A value the host writes into a time register is loaded into the running copy at the next tick. This is how software sets the clock. Two single-cycle strobes, one for each new second and one for each minute rollover, are provided for neighbouring alarm logic.

Top module: `bcd_rtc_core`

## Requirements
- R1: Register addresses are 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year and 8 control, where control bit 7 is transfer enable. After reset these read 00, 00, 00, 00, 01, 01, 01, 00 and 0x80, which is 24-hour mode with the clock running. Both strobes are low after reset.
- R2: Each tick taken while the clock runs advances hundredths by one in BCD, from 00 to 99 and then back to 00. With transfer enabled, the visible registers show the new value in the clock cycle after the tick is sampled. Without a tick, the running copy does not change.
- R3: While control bit 7 is 0, ticks do not change the visible registers, but the running copy keeps counting. After bit 7 is set back to 1, the next tick shows the running time, including every tick that passed during the freeze.
- R4: The rollover of hundredths from 99 to 00 advances seconds. Seconds going from 59 to 00 advance minutes, and minutes going from 59 to 00 advance hours.
- R5: In 24-hour mode (hours bit 6 = 0), hours run from 00 to 23, with bits 5:4 as the tens digit. Going from 23 to 00 advances the day.
- R6: In 12-hour mode (hours bit 6 = 1), bit 5 is PM and bits 4:0 hold 01 to 12. Going from 11 to 12 toggles PM. Going from 12 to 01 keeps PM. Going from 11 PM to 12 AM advances the day.
- R7: A day advance moves the weekday from 07 back to 01 and otherwise adds one. The date wraps to 01 after the last day of the month: 30 for April, June, September and November; 29 for February when the year is divisible by 4, otherwise 28; 31 for all other months. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R8: While month bit 7 is 1, ticks are ignored, and neither the running nor the visible time changes.
- R9: While month bit 6 is 0, sqw_oe is 1 and sqw_out follows sqw_ref. While it is 1, sqw_oe is 0 and sqw_out is 0.
- R10: Unused bits read as zero whatever is written. The write masks are: seconds and minutes 0x7F, hours 0x7F, weekday 0x07, date 0x3F, month 0xDF, control 0x80. Addresses 9 to 15 read 0x00.
- R11: A time register written by the host is loaded into the running copy at the next running tick that has transfer enabled, and then advances by one hundredth. This also applies to writes made while the view was frozen. Fields that were not written keep counting.
- R12: sec_pulse is high for exactly one cycle after a tick that rolls hundredths from 99 to 00. min_roll_pulse is high in that same cycle only when seconds also rolled from 59 to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100hz | input | 1 | One-cycle pulse at 100 Hz |
| sqw_ref | input | 1 | 1024 Hz reference wave to gate onto sqw_out |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe, taken on the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| sec_pulse | output | 1 | New-second strobe |
| min_roll_pulse | output | 1 | Seconds 59 to 00 strobe |
| sqw_out | output | 1 | Gated square wave |
| sqw_oe | output | 1 | Output enable for the square wave pin |

## Verification
Random valid times in both hour formats, each followed by a random run of up to 400 ticks, are compared with a binary reference model. These runs separate correct carry chaining from mistakes that only show at one digit boundary. Directed start points just before a rollover then isolate each boundary on its own: midnight with a year wrap, the end of February in leap and non-leap years, a 30-day month, and the three 12-hour transitions. A freeze window and a write made during a freeze tell a view that merely stops apart from one that loses time or drops a pending load. The oscillator-stop case and the masked-write case check at the ports that a halted clock and the unused bits leave nothing behind.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NF     = 8;
    localparam int F_HUND = 0;
    localparam int F_SEC  = 1;
    localparam int F_MIN  = 2;
    localparam int F_HOUR = 3;
    localparam int F_WDAY = 4;
    localparam int F_DATE = 5;
    localparam int F_MON  = 6;
    localparam int F_YEAR = 7;

    typedef logic [7:0] bcd_t;
    typedef bcd_t [NF-1:0] rtc_regs_t;

    // two-digit BCD increment, no wrap handling
    function automatic bcd_t bcd_inc(bcd_t v);
        bcd_t r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // bits the host may store in each visible register
    function automatic bcd_t host_mask(int idx);
        bcd_t m;
        case (idx)
            F_SEC, F_MIN, F_HOUR: m = 8'h7F;
            F_WDAY:               m = 8'h07;
            F_DATE:               m = 8'h3F;
            F_MON:                m = 8'hDF;
            default:              m = 8'hFF;
        endcase
        return m;
    endfunction

    // bits that belong to the running copy (month control bits stay visible-only)
    function automatic bcd_t core_mask(int idx);
        return (idx == F_MON) ? 8'h1F : host_mask(idx);
    endfunction

    function automatic rtc_regs_t reset_regs();
        rtc_regs_t r;
        r         = '0;
        r[F_WDAY] = 8'h01;
        r[F_DATE] = 8'h01;
        r[F_MON]  = 8'h01;
        return r;
    endfunction

endpackage

// File: rtl/rtc_month_days.sv
module rtc_month_days (
    input  logic [7:0] month_i,
    input  logic [7:0] year_i,
    output logic [7:0] last_o
);
    logic [7:0] tens_w;
    logic [7:0] year_bin;

    assign tens_w   = {4'b0, year_i[7:4]};
    assign year_bin = (tens_w << 3) + (tens_w << 1) + {4'b0, year_i[3:0]};

    always_comb begin
        case (month_i)
            8'h02:                     last_o = (year_bin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
            default:                   last_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
(
    input  rtc_regs_t cur,
    output rtc_regs_t nxt,
    output logic      new_sec,
    output logic      new_min
);
    logic [7:0] last_date;
    logic       c_sec, c_min, c_hour, c_day, c_mon, c_year;
    logic [7:0] h_val;
    logic [7:0] h_inc;

    rtc_month_days u_mdays (
        .month_i (cur[F_MON]),
        .year_i  (cur[F_YEAR]),
        .last_o  (last_date)
    );

    always_comb begin
        nxt    = cur;
        c_sec  = (cur[F_HUND] == 8'h99);
        nxt[F_HUND] = c_sec ? 8'h00 : bcd_inc(cur[F_HUND]);

        c_min = c_sec && (cur[F_SEC] == 8'h59);
        if (c_sec) nxt[F_SEC] = (cur[F_SEC] == 8'h59) ? 8'h00 : bcd_inc(cur[F_SEC]);

        c_hour = c_min && (cur[F_MIN] == 8'h59);
        if (c_min) nxt[F_MIN] = (cur[F_MIN] == 8'h59) ? 8'h00 : bcd_inc(cur[F_MIN]);

        c_day = 1'b0;
        h_val = cur[F_HOUR][6] ? {3'b0, cur[F_HOUR][4:0]} : {2'b0, cur[F_HOUR][5:0]};
        h_inc = bcd_inc(h_val);
        if (c_hour) begin
            if (cur[F_HOUR][6]) begin
                if (h_val == 8'h12) begin
                    nxt[F_HOUR] = {2'b01, cur[F_HOUR][5], 5'h01};
                end else if (h_val == 8'h11) begin
                    nxt[F_HOUR] = {2'b01, ~cur[F_HOUR][5], 5'h12};
                    c_day       = cur[F_HOUR][5];
                end else begin
                    nxt[F_HOUR] = {2'b01, cur[F_HOUR][5], h_inc[4:0]};
                end
            end else if (h_val == 8'h23) begin
                nxt[F_HOUR] = 8'h00;
                c_day       = 1'b1;
            end else begin
                nxt[F_HOUR] = {2'b00, h_inc[5:0]};
            end
        end

        c_mon = c_day && (cur[F_DATE] == last_date);
        if (c_day) begin
            nxt[F_WDAY] = (cur[F_WDAY] == 8'h07) ? 8'h01 : cur[F_WDAY] + 8'd1;
            nxt[F_DATE] = c_mon ? 8'h01 : bcd_inc(cur[F_DATE]);
        end

        c_year = c_mon && (cur[F_MON] == 8'h12);
        if (c_mon)  nxt[F_MON]  = c_year ? 8'h01 : bcd_inc(cur[F_MON]);
        if (c_year) nxt[F_YEAR] = (cur[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cur[F_YEAR]);
    end

    assign new_sec = c_sec;
    assign new_min = c_min;
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_100hz,
    input  logic              sqw_ref,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              sec_pulse,
    output logic              min_roll_pulse,
    output logic              sqw_out,
    output logic              sqw_oe
);
    localparam int                FI_W      = $clog2(NF);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NF);

    typedef struct packed {
        rtc_regs_t     int_r;
        rtc_regs_t     ext_r;
        logic [NF-1:0] pend;
        logic          te;
        logic          sec_stb;
        logic          min_stb;
    } state_t;

    state_t          q_q, q_d;
    rtc_regs_t       merged_d, base_d, adv_d;
    logic            adv_sec_d, adv_min_d;
    logic            run_d, hit_field_d;
    logic [FI_W-1:0] fidx_d;

    // pending host writes replace running fields at the next transfer
    generate
        for (genvar i = 0; i < NF; i++) begin : g_merge
            assign merged_d[i] = q_q.pend[i] ? (q_q.ext_r[i] & core_mask(i)) : q_q.int_r[i];
        end
    endgenerate

    assign base_d = q_q.te ? merged_d : q_q.int_r;

    rtc_advance u_adv (
        .cur     (base_d),
        .nxt     (adv_d),
        .new_sec (adv_sec_d),
        .new_min (adv_min_d)
    );

    assign run_d       = tick_100hz && !q_q.ext_r[F_MON][7];
    assign hit_field_d = (reg_addr < CTRL_ADDR);
    assign fidx_d      = reg_addr[FI_W-1:0];

    always_comb begin
        q_d         = q_q;
        q_d.sec_stb = run_d && adv_sec_d;
        q_d.min_stb = run_d && adv_min_d;
        if (run_d) begin
            q_d.int_r = adv_d;
            if (q_q.te) begin
                q_d.ext_r            = adv_d;
                q_d.ext_r[F_MON][7:6] = q_q.ext_r[F_MON][7:6];
                q_d.pend             = '0;
            end
        end
        if (reg_wr) begin
            if (hit_field_d) begin
                q_d.ext_r[fidx_d] = reg_wdata & host_mask(int'(fidx_d));
                q_d.pend[fidx_d]  = 1'b1;
            end else if (reg_addr == CTRL_ADDR) begin
                q_d.te = reg_wdata[7];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q.int_r   <= reset_regs();
            q_q.ext_r   <= reset_regs();
            q_q.pend    <= '0;
            q_q.te      <= 1'b1;
            q_q.sec_stb <= 1'b0;
            q_q.min_stb <= 1'b0;
        end else begin
            q_q <= q_d;
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (hit_field_d)                 reg_rdata = q_q.ext_r[fidx_d];
        else if (reg_addr == CTRL_ADDR)  reg_rdata = {q_q.te, 7'b0};
    end

    assign sec_pulse      = q_q.sec_stb;
    assign min_roll_pulse = q_q.min_stb;
    assign sqw_oe         = !q_q.ext_r[F_MON][6];
    assign sqw_out        = sqw_ref && sqw_oe;

    // frozen view only changes through the host port
    assert_frozen_view_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_q.te && !reg_wr) |=> $stable(q_q.ext_r));

    // running copy moves only on a tick
    assert_idle_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_100hz |=> $stable(q_q.int_r));

    // halted oscillator freezes the running copy
    assert_osc_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.ext_r[F_MON][7] |=> $stable(q_q.int_r));

    // minute strobe is always part of a new second
    assert_min_in_sec_R12: assert property (@(posedge clk) disable iff (!rst_n)
        min_roll_pulse |-> sec_pulse);

    assert_sec_at_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> (q_q.int_r[F_HUND] == 8'h00));

    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.ext_r[F_WDAY][7:3] == 5'd0) && (q_q.ext_r[F_DATE][7:6] == 2'd0)
        && !q_q.ext_r[F_SEC][7] && !q_q.ext_r[F_HOUR][7] && !q_q.ext_r[F_MON][5]);

    assert_sqw_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sqw_oe |-> !sqw_out);

endmodule

// File: tb/bcd_rtc_core_tb.sv
module bcd_rtc_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_100hz = 1'b0;
    logic       sqw_ref = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sec_pulse, min_roll_pulse, sqw_out, sqw_oe;

    int n_run = 0;
    int n_fail = 0;

    // reference model in binary
    int m_h, m_s, m_mi, m_hr, m_wd, m_dt, m_mo, m_yr;
    bit m_12;

    always #5 clk = ~clk;

    bcd_rtc_core u_dut (
        .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .sqw_ref(sqw_ref),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sec_pulse(sec_pulse), .min_roll_pulse(min_roll_pulse),
        .sqw_out(sqw_out), .sqw_oe(sqw_oe)
    );

    function automatic logic [7:0] to_bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] hour_reg(int hr, bit twelve);
        int h12;
        if (!twelve) return to_bcd(hr);
        h12 = (hr % 12 == 0) ? 12 : hr % 12;
        return 8'h40 | ((hr >= 12) ? 8'h20 : 8'h00) | to_bcd(h12);
    endfunction

    function automatic logic [7:0] model_byte(int i);
        case (i)
            0: return to_bcd(m_h);
            1: return to_bcd(m_s);
            2: return to_bcd(m_mi);
            3: return hour_reg(m_hr, m_12);
            4: return to_bcd(m_wd);
            5: return to_bcd(m_dt);
            6: return to_bcd(m_mo);
            default: return to_bcd(m_yr);
        endcase
    endfunction

    task automatic model_step();
        m_h++;
        if (m_h == 100) begin m_h = 0; m_s++; end
        if (m_s == 60)  begin m_s = 0; m_mi++; end
        if (m_mi == 60) begin m_mi = 0; m_hr++; end
        if (m_hr == 24) begin
            m_hr = 0;
            m_wd = (m_wd == 7) ? 1 : m_wd + 1;
            m_dt++;
            if (m_dt > mdays(m_mo, m_yr)) begin m_dt = 1; m_mo++; end
            if (m_mo > 12) begin m_mo = 1; m_yr = (m_yr + 1) % 100; end
        end
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(int a, logic [7:0] v);
        @(negedge clk);
        reg_addr = 4'(a); reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [7:0] v);
        reg_addr = 4'(a);
        #1;
        v = reg_rdata;
    endtask

    task automatic do_tick(bit advance_model);
        @(negedge clk);
        tick_100hz = 1'b1;
        @(negedge clk);
        tick_100hz = 1'b0;
        if (advance_model) model_step();
    endtask

    task automatic set_time(int h, int s, int mi, int hr, int wd, int dt, int mo, int yr, bit twelve);
        m_h = h; m_s = s; m_mi = mi; m_hr = hr; m_wd = wd; m_dt = dt; m_mo = mo; m_yr = yr; m_12 = twelve;
        for (int i = 0; i < 8; i++) wr(i, model_byte(i));
    endtask

    task automatic check_all(string req);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(i, v);
            chk(v == model_byte(i), req, $sformatf("reg %0d", i), v, model_byte(i));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic [7:0] snap [8];
        int unsigned seed;
        seed = $urandom(20240611);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and register map
        m_h = 0; m_s = 0; m_mi = 0; m_hr = 0; m_wd = 1; m_dt = 1; m_mo = 1; m_yr = 0; m_12 = 0;
        check_all("R1");
        rd(8, v); chk(v == 8'h80, "R1", "control", v, 8'h80);
        chk(!sec_pulse && !min_roll_pulse, "R1", "strobes", {sec_pulse, min_roll_pulse}, 0);

        // R2 hundredths count per tick
        for (int k = 0; k < 5; k++) do_tick(1);
        rd(0, v); chk(v == 8'h05, "R2", "hundredths", v, 8'h05);
        check_all("R2");

        // R12 new second and minute rollover strobes at midnight, with R5 R7 wraps
        set_time(99, 59, 59, 23, 7, 31, 12, 99, 0);
        do_tick(1);
        chk(sec_pulse && min_roll_pulse, "R12", "strobes at rollover", {sec_pulse, min_roll_pulse}, 3);
        @(negedge clk);
        chk(!sec_pulse && !min_roll_pulse, "R12", "strobes one cycle", {sec_pulse, min_roll_pulse}, 0);
        check_all("R5_R7");
        set_time(99, 10, 3, 4, 2, 5, 5, 5, 0);
        do_tick(1);
        chk(sec_pulse && !min_roll_pulse, "R12", "second only", {sec_pulse, min_roll_pulse}, 2);
        check_all("R4");
        set_time(50, 10, 3, 4, 2, 5, 5, 5, 0);
        do_tick(1);
        chk(!sec_pulse, "R12", "no strobe mid-second", sec_pulse, 0);

        // R7 month lengths and leap years
        set_time(99, 59, 59, 23, 3, 28, 2, 24, 0); do_tick(1); check_all("R7_leap");
        set_time(99, 59, 59, 23, 3, 29, 2, 24, 0); do_tick(1); check_all("R7_feb29");
        set_time(99, 59, 59, 23, 3, 28, 2, 23, 0); do_tick(1); check_all("R7_nonleap");
        set_time(99, 59, 59, 23, 6, 30, 4, 10, 0); do_tick(1); check_all("R7_april");

        // R6 twelve-hour transitions
        set_time(99, 59, 59, 11, 1, 10, 6, 30, 1); do_tick(1); check_all("R6_noon");
        rd(3, v); chk(v == 8'h72, "R6", "12 PM", v, 8'h72);
        set_time(99, 59, 59, 12, 1, 10, 6, 30, 1); do_tick(1);
        rd(3, v); chk(v == 8'h61, "R6", "1 PM", v, 8'h61);
        set_time(99, 59, 59, 23, 1, 10, 6, 30, 1); do_tick(1); check_all("R6_midnight");
        rd(3, v); chk(v == 8'h52, "R6", "12 AM", v, 8'h52);

        // R3 freeze keeps visible copy while counting continues
        set_time(20, 30, 15, 9, 4, 12, 8, 41, 0);
        do_tick(1);
        wr(8, 8'h00);
        for (int i = 0; i < 8; i++) rd(i, snap[i]);
        for (int k = 0; k < 90; k++) do_tick(1);
        for (int i = 0; i < 8; i++) begin
            rd(i, v); chk(v == snap[i], "R3", $sformatf("frozen reg %0d", i), v, snap[i]);
        end
        wr(8, 8'h80);
        do_tick(1);
        check_all("R3");

        // R11 write during freeze is loaded on release
        set_time(0, 10, 15, 9, 4, 12, 8, 41, 0);
        do_tick(1);
        wr(8, 8'h00);
        wr(2, 8'h42);
        rd(2, v); chk(v == 8'h42, "R11", "visible minutes", v, 8'h42);
        for (int k = 0; k < 5; k++) do_tick(1);
        wr(8, 8'h80);
        m_mi = 42;
        do_tick(1);
        check_all("R11");

        // R8 halted clock ignores ticks
        set_time(33, 10, 15, 9, 4, 12, 8, 41, 0);
        do_tick(1);
        wr(6, 8'h80 | to_bcd(m_mo));
        rd(6, v); chk(v == (8'h80 | to_bcd(m_mo)), "R8", "month ctrl", v, 8'h80 | to_bcd(m_mo));
        for (int k = 0; k < 10; k++) do_tick(0);
        rd(0, v); chk(v == to_bcd(m_h), "R8", "hundredths held", v, to_bcd(m_h));
        wr(6, to_bcd(m_mo));
        do_tick(1);
        check_all("R8");

        // R9 square wave gating
        sqw_ref = 1'b1; #1;
        chk(sqw_oe && sqw_out, "R9", "enabled", {sqw_oe, sqw_out}, 3);
        wr(6, 8'h40 | to_bcd(m_mo)); #1;
        chk(!sqw_oe && !sqw_out, "R9", "disabled", {sqw_oe, sqw_out}, 0);
        wr(6, to_bcd(m_mo));
        sqw_ref = 1'b0;

        // R10 unused bits and unmapped addresses
        wr(4, 8'hFB); rd(4, v); chk(v == 8'h03, "R10", "weekday mask", v, 8'h03);
        wr(1, 8'hA5); rd(1, v); chk(v == 8'h25, "R10", "seconds mask", v, 8'h25);
        wr(5, 8'hC5); rd(5, v); chk(v == 8'h05, "R10", "date mask", v, 8'h05);
        wr(3, 8'h92); rd(3, v); chk(v == 8'h12, "R10", "hours mask", v, 8'h12);
        wr(6, 8'h23); rd(6, v); chk(v == 8'h03, "R10", "month mask", v, 8'h03);
        wr(8, 8'h7F); rd(8, v); chk(v == 8'h00, "R10", "control mask", v, 8'h00);
        wr(8, 8'h80);
        rd(12, v); chk(v == 8'h00, "R10", "unmapped", v, 8'h00);

        // R4 R5 R6 R7 random start points and run lengths
        for (int it = 0; it < 24; it++) begin
            int mo, yr, n;
            mo = int'($urandom_range(12, 1));
            yr = int'($urandom_range(99, 0));
            set_time(int'($urandom_range(99, 0)), int'($urandom_range(59, 0)),
                     int'($urandom_range(59, 0)), int'($urandom_range(23, 0)),
                     int'($urandom_range(7, 1)), int'($urandom_range(mdays(mo, yr), 1)),
                     mo, yr, bit'($urandom_range(1, 0)));
            n = int'($urandom_range(400, 1));
            for (int k = 0; k < n; k++) do_tick(1);
            check_all("R4_random");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule